// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K words by 8 bits. The host raises a single-beat read or write request. The controller converts it into chip-select, write-enable and output-enable strobes, with every minimum pulse width counted in whole clock cycles. All strobes and the memory address come from registers, so they change only on clock edges. The data bus is split into an outgoing value, an incoming value and a drive enable for the pad.

Timing minimums are given in nanoseconds. Each one is rounded up to whole cycles of the `CLK_NS` parameter. A speed-grade parameter chooses between a fast set of minimums and a slow set. Write enable falls only while both selects are active. Output enable stays high for the whole of a write. The controller waits a turnaround interval before it drives write data, so that it never drives the bus at the same time as the memory. Every access ends with both selects released, so two consecutive accesses are always separated by at least one cycle with the memory deselected.

The host holds `req` and its fields until it sees `ready`, and it drops `req` on that same cycle. `ready` pulses for one cycle, both when read data is available on `rdata` and when a write has finished.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `ready`=0.
- R2: A read drives both selects active, `mem_we_n`=1 and `mem_oe_n`=0 for exactly the rounded read access count. This is 6 cycles at the defaults (10 ns clock, fast grade). The data bus is sampled at the end of the last active cycle. In the next cycle the strobes are inactive, `ready`=1, and `rdata` holds the byte last written to that address.
- R3: `mem_we_n` is low only while `mem_cs_n`=0 and `mem_cs`=1, and `mem_oe_n` is high whenever `mem_we_n` is low. A completed write stores `req_wdata` at `req_addr`.
- R4: Write enable stays low for at least the largest of three rounded minimums: write pulse width, address-valid-to-end and select-to-end. This is 5 cycles at the defaults. Write data is driven for at least the rounded data setup time before write enable rises, which is 3 cycles at the defaults.
- R5: `mem_dq_oe` rises only after `mem_we_n` has been low, with `mem_oe_n` high, for the rounded bus-release count (2 cycles at the defaults). It falls exactly one cycle after `mem_we_n` rises, and it is never high outside a write and that one cycle.
- R6: `mem_dq_oe` is never high in a cycle where the memory drives the bus, that is, where both selects are active, `mem_we_n`=1 and `mem_oe_n`=0.
- R7: `ready` lasts exactly one cycle per request, and it never appears without a request. A request is not accepted in the cycle `ready` is high. At the defaults, from an idle controller, `ready` follows the raising of `req` by 7 cycles for a read and by 6 cycles for a write. When the request is raised in the `ready` cycle of the previous access, these become 8 and 7.
- R8: In every cycle where `ready` is high, both selects are inactive, so consecutive accesses are separated by at least one deselected cycle.
- R9: `mem_addr` does not change in any two consecutive cycles where `mem_cs_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, held until `ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data received from the memory |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_out` |

## Verification
If the sequencer's cycle counter loads a wrong value, the error shows at the pins on the first access. An access window one cycle short makes the memory model return garbage, or flags a short write pulse, as soon as the strobes drop. If the state register takes a wrong step, the result shows within one cycle as drive enable overlapping a read, write enable outside the selects, or `ready` held for two cycles. A wrong data path register shows only when its address is read back, as a mismatch between `rdata` and the shadow copy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WR_TURN,
    ST_WR_DRIVE,
    ST_WR_RELEASE
  } seq_state_t;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 6,
  parameter int TURN_CYC = 2,
  parameter int DRV_CYC  = 3,
  parameter int CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_we,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             cs_n,
  output logic             cs,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe,
  output logic             ready
);

  seq_state_t state_q;

  always_comb begin
    accept   = (state_q == ST_IDLE) && req && !ready;
    capture  = (state_q == ST_READ) && tmr_done;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_we ? CNT_W'(TURN_CYC - 1) : CNT_W'(RD_CYC - 1);
    end else if ((state_q == ST_WR_TURN) && tmr_done) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(DRV_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n    <= 1'b1;
      cs      <= 1'b0;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      ready   <= 1'b0;
    end else begin
      ready <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            cs_n <= 1'b0;
            cs   <= 1'b1;
            if (req_we) begin
              we_n    <= 1'b0;
              oe_n    <= 1'b1;
              state_q <= ST_WR_TURN;
            end else begin
              we_n    <= 1'b1;
              oe_n    <= 1'b0;
              state_q <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (tmr_done) begin
            cs_n    <= 1'b1;
            cs      <= 1'b0;
            oe_n    <= 1'b1;
            ready   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WR_TURN: begin
          if (tmr_done) begin
            dq_oe   <= 1'b1;
            state_q <= ST_WR_DRIVE;
          end
        end
        ST_WR_DRIVE: begin
          if (tmr_done) begin
            we_n    <= 1'b1;
            cs_n    <= 1'b1;
            cs      <= 1'b0;
            ready   <= 1'b1;
            state_q <= ST_WR_RELEASE;
          end
        end
        ST_WR_RELEASE: begin
          dq_oe   <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (capture)
      rdata <= mem_dq_in;
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 10,
  parameter bit FAST_GRADE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  // grade minimums in ns
  localparam int ACC_NS   = FAST_GRADE ? 55 : 70;
  localparam int OEV_NS   = FAST_GRADE ? 30 : 35;
  localparam int PULSE_NS = FAST_GRADE ? 45 : 50;
  localparam int ADEND_NS = FAST_GRADE ? 50 : 55;
  localparam int SLEND_NS = FAST_GRADE ? 50 : 55;
  localparam int SETUP_NS = FAST_GRADE ? 25 : 30;
  localparam int FLOAT_NS = FAST_GRADE ? 20 : 25;

  localparam int RD_CYC     = imax(1, imax(ns2cyc(ACC_NS, CLK_NS), ns2cyc(OEV_NS, CLK_NS)));
  localparam int TURN_CYC   = imax(1, ns2cyc(FLOAT_NS, CLK_NS));
  localparam int WE_LOW_CYC = imax(ns2cyc(PULSE_NS, CLK_NS),
                                   imax(ns2cyc(ADEND_NS, CLK_NS), ns2cyc(SLEND_NS, CLK_NS)));
  localparam int DRV_CYC    = imax(1, imax(ns2cyc(SETUP_NS, CLK_NS), WE_LOW_CYC - TURN_CYC));
  localparam int CNT_W      = $clog2(imax(RD_CYC, imax(TURN_CYC, DRV_CYC)) + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             accept;
  logic             capture;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_ctrl_seq #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .DRV_CYC  (DRV_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_we   (req_we),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .accept   (accept),
    .capture  (capture),
    .cs_n     (mem_cs_n),
    .cs       (mem_cs),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe),
    .ready    (ready)
  );

  sram_ctrl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rdata      (rdata)
  );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int TURN   = 2,
  parameter int WE_MIN = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  logic [7:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      low_cnt <= '0;
    else if (!mem_we_n)
      low_cnt <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1;
    else
      low_cnt <= '0;
  end

  AST_WE_INSIDE_SELECT: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_cs)); // R3
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n); // R3
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (low_cnt >= 8'(WE_MIN))); // R4
  AST_DRIVE_AFTER_TURN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (!mem_we_n && low_cnt >= 8'(TURN))); // R5
  AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> !mem_dq_oe); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R6
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready); // R7
  AST_GAP_ON_READY: assert property (@(posedge clk) disable iff (rst)
    ready |-> (mem_cs_n && !mem_cs)); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R9

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .TURN   (TURN_CYC),
  .WE_MIN (WE_LOW_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .mem_cs_n  (mem_cs_n),
  .mem_cs    (mem_cs),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/sim_sram_strobe_ctrl.sv
module sim_sram_strobe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int RD_EXP = 6;
  localparam int TURN_EXP = 2;
  localparam int WE_EXP = 5;
  localparam int SETUP_EXP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic ready;
  logic [DW-1:0] rdata;
  logic mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 8'hEE;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_strobe_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  int n_checks = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    bit         we;
    int         addr;
    logic [7:0] data;
  } item_t;

  item_t       sb_q[$];
  logic [7:0]  mem[int];
  logic [7:0]  shadow[int];

  // memory model and monitor state
  int         rcnt = 0, wcnt = 0, dcnt = 0;
  bit         rel_pending = 0, rel_check = 0, prev_sel = 0, last_ready = 0;
  int         waddr = 0;
  logic [7:0] wlatch = 8'h00;
  logic [AW-1:0] prev_addr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      bit sel, rd_act, wr_act;
      sel    = !mem_cs_n && mem_cs;
      rd_act = sel && mem_we_n && !mem_oe_n;
      wr_act = sel && !mem_we_n;
      if (rd_act && mem_dq_oe) chk(0, "R6 contention", 1, 0);
      if (!mem_we_n && !sel) chk(0, "R3 we outside select", 1, 0);
      if (!mem_we_n && !mem_oe_n) chk(0, "R3 oe low during write", 1, 0);
      if (sel && prev_sel && mem_addr != prev_addr)
        chk(0, "R9 address moved", int'(mem_addr), int'(prev_addr));
      // read side
      if (rd_act) begin
        rcnt++;
        mem_dq_in = (rcnt >= RD_EXP) ? (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00)
                                     : 8'hEE;
      end else begin
        if (rcnt != 0) begin
          chk(rcnt == RD_EXP, "R2 read strobe width", rcnt, RD_EXP);
          chk(ready == 1'b1, "R2 ready after strobes drop", int'(ready), 1);
        end
        rcnt = 0;
        mem_dq_in = 8'hEE;
      end
      // write side
      if (rel_check) begin
        chk(!mem_dq_oe, "R5 bus released", int'(mem_dq_oe), 0);
        rel_check = 0;
      end else if (wr_act) begin
        if (mem_dq_oe) begin
          if (dcnt == 0) chk(wcnt >= TURN_EXP, "R5 turnaround", wcnt, TURN_EXP);
          dcnt++;
          wlatch = mem_dq_out;
        end
        waddr = int'(mem_addr);
        wcnt++;
      end else if (wcnt != 0) begin
        chk(wcnt >= WE_EXP, "R4 write pulse", wcnt, WE_EXP);
        chk(dcnt >= SETUP_EXP, "R4 data setup", dcnt, SETUP_EXP);
        mem[waddr] = wlatch;
        wcnt = 0;
        dcnt = 0;
        rel_check = 1;
      end else if (mem_dq_oe) begin
        chk(0, "R5 drive outside write", 1, 0);
      end
      // scoreboard
      if (ready) begin
        chk(!sel, "R8 selects idle on ready", int'(sel), 0);
        if (last_ready) chk(0, "R7 ready longer than one cycle", 1, 0);
        if (sb_q.size() == 0) begin
          chk(0, "R7 ready without request", 1, 0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          if (it.we)
            chk(mem.exists(it.addr) && mem[it.addr] == it.data, "R3 write stored",
                mem.exists(it.addr) ? int'(mem[it.addr]) : -1, int'(it.data));
          else
            chk(rdata == it.data, "R2 read data", int'(rdata), int'(it.data));
        end
      end
      last_ready = ready;
      prev_sel   = sel;
      prev_addr  = mem_addr;
    end
  end

  task automatic access(input bit we, input int addr, input logic [7:0] d, input int exp_lat);
    item_t it;
    int lat;
    it.we   = we;
    it.addr = addr;
    it.data = we ? d : (shadow.exists(addr) ? shadow[addr] : 8'h00);
    if (we) shadow[addr] = d;
    sb_q.push_back(it);
    req       = 1'b1;
    req_we    = we;
    req_addr  = AW'(addr);
    req_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ready);
    req = 1'b0;
    if (exp_lat != 0) chk(lat == exp_lat, "R7 request to ready latency", lat, exp_lat);
  endtask

  task automatic check_idle(input string tag);
    chk(mem_cs_n == 1'b1, tag, int'(mem_cs_n), 1);
    chk(mem_cs == 1'b0, tag, int'(mem_cs), 0);
    chk(mem_we_n == 1'b1 && mem_oe_n == 1'b1, tag, int'({mem_we_n, mem_oe_n}), 3);
    chk(mem_dq_oe == 1'b0 && ready == 1'b0, tag, int'({mem_dq_oe, ready}), 0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");
    // idle starts
    access(1'b1, 32'h00000, 8'h3C, 6);
    repeat (2) @(negedge clk);
    access(1'b1, 32'h1FFFF, 8'hFF, 6);
    repeat (2) @(negedge clk);
    access(1'b0, 32'h1FFFF, 8'h00, 7);
    // back-to-back in every direction pair
    access(1'b1, 32'h12345, 8'hA5, 7);
    access(1'b0, 32'h00000, 8'h00, 8);
    access(1'b0, 32'h12345, 8'h00, 8);
    access(1'b1, 32'h12345, 8'h5A, 7);
    access(1'b1, 32'h00001, 8'h00, 7);
    access(1'b0, 32'h12345, 8'h00, 8);
    access(1'b0, 32'h00001, 8'h00, 8);
    // address/data pattern sweep
    for (int i = 0; i < 24; i++)
      access(1'b1, (i * 7919 + 3) & 32'h1FFFF, 8'((i * 37) + 1), 0);
    for (int i = 23; i >= 0; i--)
      access(1'b0, (i * 7919 + 3) & 32'h1FFFF, 8'h00, 0);
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R7 all requests answered", sb_q.size(), 0);
    check_idle("R1 quiet after traffic");
    summary();
    $finish;
  end

endmodule